// File: doc/BRIEF.md
# Memory Operation Ordering Queues

This block sits between dispatch and the memory pipelines of an out-of-order core. Each memory operation is written at dispatch, in program order, into one of two slot pools. Loads and load barriers go to the load pool. Stores, store barriers and full barriers go to the store pool. Every slot also receives a global age tag, so that entries can be ordered across the two pools. Each cycle the block works out, for every slot, whether that operation may be sent to memory under a relaxed ordering model. It then frees a slot when memory reports that the operation has completed.

Barriers never go to memory. A barrier holds its slot and stands in the way of younger operations of the classes it guards. It counts as executed once nothing older is left in either pool, and it then frees itself. A configuration bit chooses whether loads may be assumed never to alias stores. The block does no address comparison and no forwarding, and it performs no memory access.

Top module: `lsq_order_unit`

## Requirements
- R1: `lq_ready` is low exactly when every load-pool slot is occupied, and `sq_ready` is low exactly when every store-pool slot is occupied. A dispatch whose target pool is full is dropped and changes no state. A full load pool leaves `sq_ready` high.
- R2: A plain store gets issue permission only when no older entry of any kind remains in the store pool.
- R3: A plain store never gets issue permission while an older load-pool entry remains, whatever the value of `cfg_no_alias`.
- R4: Plain loads that have no older barrier or blocking store all hold issue permission together, whatever their order.
- R5: A plain load behind an older plain store gets permission only while `cfg_no_alias` is 1. The setting takes effect in the same cycle it changes.
- R6: A load barrier (kind 2, load pool) withholds permission from every younger load. It has no effect on loads older than itself.
- R7: A store barrier (kind 3, store pool) withholds permission from every younger store. Younger loads keep their permission.
- R8: A full barrier (kind 4, store pool) withholds permission from both younger loads and younger stores.
- R9: A barrier never shows issue permission and needs no completion. If it is the oldest live entry during a cycle, its slot is freed at the next clock edge.
- R10: A completion (`ld_done_valid`/`st_done_valid` with an index) frees a slot that holds a plain load or a plain store. A completion aimed at a barrier slot or an empty slot is ignored.
- R11: After reset both pools are empty, both ready outputs are high and no slot has permission.
- R12: `disp_kind` is decoded as 0 load, 1 store, 2 load barrier, 3 store barrier and 4 full barrier, and values 5 to 7 are ignored. An accepted operation takes the lowest-numbered free slot of its pool. That slot index is shown on `disp_slot` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_no_alias | input | 1 | 1: loads may pass older plain stores |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_kind | input | 3 | Operation kind (see R12) |
| disp_slot | output | IDX_W | Slot that the request lands in |
| lq_ready | output | 1 | Load pool has a free slot |
| sq_ready | output | 1 | Store pool has a free slot |
| ld_done_valid | input | 1 | Load completion strobe |
| ld_done_idx | input | IDX_W | Load-pool slot completed |
| st_done_valid | input | 1 | Store completion strobe |
| st_done_idx | input | IDX_W | Store-pool slot completed |
| lq_issue_ok | output | LQ_DEPTH | Per-slot load issue permission |
| sq_issue_ok | output | SQ_DEPTH | Per-slot store issue permission |

## Verification
The hardest state to reach from the ports is a barrier that has just become the oldest entry. In that cycle it is still live and still blocking, and one edge later it is gone. To reach it, the stimulus places a barrier behind an older plain operation with younger work behind it. It then completes the older operation and samples permissions on two successive cycles, expecting the younger work to be blocked on the first and released on the second. Cross-pool ordering gets the same treatment: loads and stores are interleaved so that age, and not slot number, decides the result.

// File: rtl/lsq_pkg.sv
// Shared types for the memory ordering queues.
// Assumes operation codes are fixed by the dispatch interface.
package lsq_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_LBAR  = 3'd2,
        OP_SBAR  = 3'd3,
        OP_FBAR  = 3'd4
    } mem_op_e;
endpackage

// File: rtl/lsq_entry_queue.sv
// One slot pool: holds valid, kind and age per slot, allocates the
// lowest free slot, frees plain entries on completion and barriers on
// the retire mask. Assumes alloc_en is only raised when has_free is set.
module lsq_entry_queue
    import lsq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2,
    parameter int AGE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  mem_op_e          alloc_kind,
    input  logic [AGE_W-1:0] alloc_age,
    input  logic             done_en,
    input  logic [IDX_W-1:0] done_idx,
    input  logic [DEPTH-1:0] retire_mask,
    output logic [DEPTH-1:0] ent_vld,
    output mem_op_e          ent_kind [DEPTH],
    output logic [AGE_W-1:0] ent_age  [DEPTH],
    output logic [IDX_W-1:0] free_idx,
    output logic             has_free
);
    // Lowest-numbered empty slot.
    always_comb begin
        free_idx = '0;
        has_free = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_vld[i]) begin
                free_idx = IDX_W'(i);
                has_free = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Slot state: fill on allocate, clear on barrier retire or completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[g]  <= 1'b0;
                ent_kind[g] <= OP_LOAD;
                ent_age[g]  <= '0;
            end else if (alloc_en && free_idx == IDX_W'(g)) begin
                ent_vld[g]  <= 1'b1;
                ent_kind[g] <= alloc_kind;
                ent_age[g]  <= alloc_age;
            end else if (retire_mask[g]) begin
                ent_vld[g]  <= 1'b0;
            end else if (done_en && done_idx == IDX_W'(g) &&
                         (ent_kind[g] == OP_LOAD || ent_kind[g] == OP_STORE)) begin
                ent_vld[g]  <= 1'b0;
            end
        end
    end

    // R10: a completed plain entry is empty on the next cycle.
    p_done_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_en && int'(done_idx) < DEPTH && ent_vld[done_idx] &&
         (ent_kind[done_idx] == OP_LOAD || ent_kind[done_idx] == OP_STORE))
        |=> !ent_vld[$past(done_idx)]);

    // R12: an allocation lands in the slot it advertised.
    p_alloc_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> ent_vld[$past(free_idx)]);
endmodule

// File: rtl/lsq_order_logic.sv
// Pass/no-pass network: from both pools' valid, kind and age state it
// derives per-slot issue permission and barrier retirement.
// Assumes fewer than 2**(AGE_W-1) live entries so wrapped ages compare.
module lsq_order_logic
    import lsq_pkg::*;
#(
    parameter int LQ_DEPTH = 4,
    parameter int SQ_DEPTH = 4,
    parameter int AGE_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_no_alias,
    input  logic [LQ_DEPTH-1:0] lq_vld,
    input  mem_op_e             lq_kind [LQ_DEPTH],
    input  logic [AGE_W-1:0]    lq_age  [LQ_DEPTH],
    input  logic [SQ_DEPTH-1:0] sq_vld,
    input  mem_op_e             sq_kind [SQ_DEPTH],
    input  logic [AGE_W-1:0]    sq_age  [SQ_DEPTH],
    output logic [LQ_DEPTH-1:0] lq_ok,
    output logic [SQ_DEPTH-1:0] sq_ok,
    output logic [LQ_DEPTH-1:0] lq_ret,
    output logic [SQ_DEPTH-1:0] sq_ret
);
    // True when age a was handed out before age b.
    function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] d;
        d = a - b;
        return d[AGE_W-1];
    endfunction

    // Load-pool slots: load permission and load-barrier retirement.
    always_comb begin
        for (int i = 0; i < LQ_DEPTH; i++) begin
            logic any_older;
            logic blk;
            any_older = 1'b0;
            blk       = 1'b0;
            for (int j = 0; j < LQ_DEPTH; j++) begin
                if (j != i && lq_vld[j] && older(lq_age[j], lq_age[i])) begin
                    any_older = 1'b1;
                    if (lq_kind[j] == OP_LBAR) blk = 1'b1;
                end
            end
            for (int j = 0; j < SQ_DEPTH; j++) begin
                if (sq_vld[j] && older(sq_age[j], lq_age[i])) begin
                    any_older = 1'b1;
                    if (sq_kind[j] == OP_FBAR) blk = 1'b1;
                    if (sq_kind[j] == OP_STORE && !cfg_no_alias) blk = 1'b1;
                end
            end
            lq_ok[i]  = lq_vld[i] && lq_kind[i] == OP_LOAD && !blk;
            lq_ret[i] = lq_vld[i] && lq_kind[i] == OP_LBAR && !any_older;
        end
    end

    // Store-pool slots: store permission and store/full-barrier retirement.
    always_comb begin
        for (int i = 0; i < SQ_DEPTH; i++) begin
            logic any_older;
            any_older = 1'b0;
            for (int j = 0; j < SQ_DEPTH; j++)
                if (j != i && sq_vld[j] && older(sq_age[j], sq_age[i])) any_older = 1'b1;
            for (int j = 0; j < LQ_DEPTH; j++)
                if (lq_vld[j] && older(lq_age[j], sq_age[i])) any_older = 1'b1;
            sq_ok[i]  = sq_vld[i] && sq_kind[i] == OP_STORE && !any_older;
            sq_ret[i] = sq_vld[i] && (sq_kind[i] == OP_SBAR || sq_kind[i] == OP_FBAR) && !any_older;
        end
    end

    // R2: stores leave strictly in order, so at most one may hold permission.
    p_single_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sq_ok) <= 1);

    // R9: only the single oldest entry can be a retiring barrier.
    p_single_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lq_ret) + $countones(sq_ret)) <= 1);

    // R9: a retiring barrier coexists with no permitted store.
    p_retire_blocks_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|sq_ret || |lq_ret) |-> sq_ok == '0);
endmodule

// File: rtl/lsq_order_unit.sv
// Top: routes dispatch into the load or store pool with a global age
// tag, and exposes per-slot issue permission from the ordering network.
// Assumes one dispatch per cycle and completion only for issued slots.
module lsq_order_unit
    import lsq_pkg::*;
#(
    parameter int LQ_DEPTH = 4,
    parameter int SQ_DEPTH = 4,
    localparam int MAX_D   = (LQ_DEPTH > SQ_DEPTH) ? LQ_DEPTH : SQ_DEPTH,
    localparam int IDX_W   = (MAX_D > 1) ? $clog2(MAX_D) : 1,
    localparam int AGE_W   = $clog2(LQ_DEPTH + SQ_DEPTH) + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_no_alias,
    input  logic                disp_valid,
    input  logic [2:0]          disp_kind,
    output logic [IDX_W-1:0]    disp_slot,
    output logic                lq_ready,
    output logic                sq_ready,
    input  logic                ld_done_valid,
    input  logic [IDX_W-1:0]    ld_done_idx,
    input  logic                st_done_valid,
    input  logic [IDX_W-1:0]    st_done_idx,
    output logic [LQ_DEPTH-1:0] lq_issue_ok,
    output logic [SQ_DEPTH-1:0] sq_issue_ok
);
    mem_op_e             kind;
    logic                to_lq, to_sq, acc_lq, acc_sq;
    logic [AGE_W-1:0]    age_ctr;
    logic [LQ_DEPTH-1:0] lq_vld, lq_ret;
    logic [SQ_DEPTH-1:0] sq_vld, sq_ret;
    mem_op_e             lq_kind [LQ_DEPTH];
    mem_op_e             sq_kind [SQ_DEPTH];
    logic [AGE_W-1:0]    lq_age  [LQ_DEPTH];
    logic [AGE_W-1:0]    sq_age  [SQ_DEPTH];
    logic [IDX_W-1:0]    lq_free, sq_free;

    // Decode the target pool; unknown codes target neither.
    always_comb begin
        kind   = mem_op_e'(disp_kind);
        to_lq  = kind == OP_LOAD || kind == OP_LBAR;
        to_sq  = kind == OP_STORE || kind == OP_SBAR || kind == OP_FBAR;
        acc_lq = disp_valid && to_lq && lq_ready;
        acc_sq = disp_valid && to_sq && sq_ready;
        disp_slot = to_lq ? lq_free : sq_free;
    end

    // Global age tag, advanced once per accepted dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n)                age_ctr <= '0;
        else if (acc_lq || acc_sq) age_ctr <= age_ctr + 1'b1;
    end

    lsq_entry_queue #(.DEPTH(LQ_DEPTH), .IDX_W(IDX_W), .AGE_W(AGE_W)) u_lq (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(acc_lq), .alloc_kind(kind), .alloc_age(age_ctr),
        .done_en(ld_done_valid), .done_idx(ld_done_idx), .retire_mask(lq_ret),
        .ent_vld(lq_vld), .ent_kind(lq_kind), .ent_age(lq_age),
        .free_idx(lq_free), .has_free(lq_ready)
    );

    lsq_entry_queue #(.DEPTH(SQ_DEPTH), .IDX_W(IDX_W), .AGE_W(AGE_W)) u_sq (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(acc_sq), .alloc_kind(kind), .alloc_age(age_ctr),
        .done_en(st_done_valid), .done_idx(st_done_idx), .retire_mask(sq_ret),
        .ent_vld(sq_vld), .ent_kind(sq_kind), .ent_age(sq_age),
        .free_idx(sq_free), .has_free(sq_ready)
    );

    lsq_order_logic #(.LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH), .AGE_W(AGE_W)) u_ord (
        .clk(clk), .rst_n(rst_n), .cfg_no_alias(cfg_no_alias),
        .lq_vld(lq_vld), .lq_kind(lq_kind), .lq_age(lq_age),
        .sq_vld(sq_vld), .sq_kind(sq_kind), .sq_age(sq_age),
        .lq_ok(lq_issue_ok), .sq_ok(sq_issue_ok),
        .lq_ret(lq_ret), .sq_ret(sq_ret)
    );

    // R1: a dispatch to a full load pool leaves the load pool unchanged.
    p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && to_lq && !lq_ready && !ld_done_valid && lq_ret == '0)
        |=> $stable(lq_vld));
endmodule

// File: tb/lsq_order_unit_tb.sv
module lsq_order_unit_tb;
    localparam int LQ = 4;
    localparam int SQ = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_no_alias = 1'b1;
    logic          disp_valid = 1'b0;
    logic [2:0]    disp_kind = 3'd0;
    logic [1:0]    disp_slot;
    logic          lq_ready, sq_ready;
    logic          ld_done_valid = 1'b0;
    logic [1:0]    ld_done_idx = '0;
    logic          st_done_valid = 1'b0;
    logic [1:0]    st_done_idx = '0;
    logic [LQ-1:0] lq_issue_ok;
    logic [SQ-1:0] sq_issue_ok;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    lsq_order_unit #(.LQ_DEPTH(LQ), .SQ_DEPTH(SQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_no_alias(cfg_no_alias),
        .disp_valid(disp_valid), .disp_kind(disp_kind), .disp_slot(disp_slot),
        .lq_ready(lq_ready), .sq_ready(sq_ready),
        .ld_done_valid(ld_done_valid), .ld_done_idx(ld_done_idx),
        .st_done_valid(st_done_valid), .st_done_idx(st_done_idx),
        .lq_issue_ok(lq_issue_ok), .sq_issue_ok(sq_issue_ok)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic disp(input logic [2:0] k, output int slot);
        @(negedge clk);
        disp_valid = 1'b1;
        disp_kind  = k;
        #1 slot = int'(disp_slot);
        @(posedge clk);
        #1 disp_valid = 1'b0;
    endtask

    task automatic ldone(input int idx);
        @(negedge clk);
        ld_done_valid = 1'b1;
        ld_done_idx   = 2'(idx);
        @(posedge clk);
        #1 ld_done_valid = 1'b0;
    endtask

    task automatic sdone(input int idx);
        @(negedge clk);
        st_done_valid = 1'b1;
        st_done_idx   = 2'(idx);
        @(posedge clk);
        #1 st_done_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11", "lq_ready", int'(lq_ready), 1);
        chk("R11", "sq_ready", int'(sq_ready), 1);
        chk("R11", "permissions", int'({lq_issue_ok, sq_issue_ok}), 0);
    endtask

    task automatic t_loads_free();
        int s0, s1, s2;
        disp(3'd0, s0); disp(3'd0, s1); disp(3'd0, s2);
        chk("R12", "slot order", s0 * 16 + s1 * 4 + s2, 16'h06);
        @(negedge clk);
        chk("R4", "three loads permitted", int'(lq_issue_ok), 4'b0111);
        ldone(0); ldone(1); ldone(2);
        @(negedge clk);
        chk("R10", "loads freed", int'(lq_issue_ok), 0);
    endtask

    task automatic t_alias();
        int s, l;
        cfg_no_alias = 1'b0;
        disp(3'd1, s); disp(3'd0, l);
        @(negedge clk);
        chk("R5", "load behind store, aliasing", int'(lq_issue_ok), 0);
        chk("R2", "oldest store permitted", int'(sq_issue_ok), 4'b0001);
        cfg_no_alias = 1'b1;
        #1 chk("R5", "load behind store, no-alias", int'(lq_issue_ok), 4'b0001);
        sdone(s); ldone(l);
        disp(3'd0, l); disp(3'd1, s);
        @(negedge clk);
        chk("R3", "store behind load, no-alias", int'(sq_issue_ok), 0);
        ldone(l);
        @(negedge clk);
        chk("R3", "store released after load", int'(sq_issue_ok), 4'b0001);
        sdone(s);
    endtask

    task automatic t_store_order();
        int a, b;
        disp(3'd1, a); disp(3'd1, b);
        @(negedge clk);
        chk("R2", "only older store", int'(sq_issue_ok), 4'b0001);
        sdone(a);
        @(negedge clk);
        chk("R2", "younger store after", int'(sq_issue_ok), 4'b0010);
        sdone(b);
    endtask

    task automatic t_load_barrier();
        int l0, b, l2, s;
        disp(3'd0, l0); disp(3'd2, b); disp(3'd0, l2); disp(3'd1, s);
        @(negedge clk);
        chk("R6", "older load free, younger held", int'(lq_issue_ok), 4'b0001);
        chk("R3", "store behind barrier", int'(sq_issue_ok), 0);
        ldone(l0);
        @(negedge clk);
        chk("R9", "barrier oldest but still blocking", int'(lq_issue_ok), 0);
        @(negedge clk);
        chk("R9", "barrier retired, load free", int'(lq_issue_ok), 4'b0100);
        chk("R3", "store still behind load", int'(sq_issue_ok), 0);
        ldone(l2);
        @(negedge clk);
        chk("R3", "store free", int'(sq_issue_ok), 4'b0001);
        sdone(s);
    endtask

    task automatic t_store_barrier();
        int s0, b, s2, l;
        disp(3'd1, s0); disp(3'd3, b); disp(3'd1, s2); disp(3'd0, l);
        @(negedge clk);
        chk("R7", "store before barrier only", int'(sq_issue_ok), 4'b0001);
        chk("R7", "load passes store barrier", int'(lq_issue_ok), 4'b0001);
        sdone(s0);
        @(negedge clk);
        chk("R7", "younger store held", int'(sq_issue_ok), 0);
        @(negedge clk);
        chk("R7", "younger store after retire", int'(sq_issue_ok), 4'b0100);
        sdone(s2); ldone(l);
    endtask

    task automatic t_full_barrier();
        int l0, b, l1, s;
        disp(3'd0, l0); disp(3'd4, b); disp(3'd0, l1); disp(3'd1, s);
        @(negedge clk);
        chk("R8", "younger load held", int'(lq_issue_ok), 4'b0001);
        chk("R8", "younger store held", int'(sq_issue_ok), 0);
        ldone(l0);
        @(negedge clk);
        @(negedge clk);
        chk("R8", "load after full barrier", int'(lq_issue_ok), 4'b0010);
        ldone(l1);
        @(negedge clk);
        chk("R8", "store after full barrier", int'(sq_issue_ok), 4'b0010);
        sdone(s);
    endtask

    task automatic t_barrier_done_ignored();
        int l0, b, l2, x;
        disp(3'd0, l0); disp(3'd2, b); disp(3'd0, l2);
        ldone(b);
        ldone(3);
        @(negedge clk);
        chk("R10", "done on barrier ignored", int'(lq_issue_ok), 4'b0001);
        disp(3'd0, x);
        chk("R10", "empty-slot done ignored, slot 3 filled", x, 3);
        ldone(l0); ldone(l2); ldone(x);
        @(negedge clk);
        @(negedge clk);
        chk("R9", "lone barrier retired, pool empty", int'(lq_issue_ok), 0);
        disp(3'd2, x);
        @(negedge clk);
        chk("R9", "lone barrier no permission", int'(lq_issue_ok), 0);
        @(negedge clk);
        disp(3'd0, x);
        chk("R9", "lone barrier freed its slot", x, 0);
        ldone(x);
    endtask

    task automatic t_full_pool();
        int s, x;
        for (int i = 0; i < LQ; i++) disp(3'd0, s);
        @(negedge clk);
        chk("R1", "lq_ready when full", int'(lq_ready), 0);
        chk("R1", "sq_ready unaffected", int'(sq_ready), 1);
        disp(3'd0, s);
        @(negedge clk);
        chk("R1", "dropped load changes nothing", int'(lq_issue_ok), 4'b1111);
        ldone(2);
        disp(3'd0, s);
        chk("R12", "refill lowest free", s, 2);
        disp(3'd7, s);
        @(negedge clk);
        chk("R12", "kind 7 ignored (sq)", int'(sq_issue_ok), 0);
        chk("R12", "kind 7 ignored (lq)", int'(lq_issue_ok), 4'b1111);
        disp(3'd1, x);
        chk("R12", "store pool untouched", x, 0);
        for (int i = 0; i < LQ; i++) ldone(i);
        sdone(x);
        @(negedge clk);
        chk("R1", "ready restored", int'({lq_ready, sq_ready}), 3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_loads_free();
        t_alias();
        t_store_order();
        t_load_barrier();
        t_store_barrier();
        t_full_barrier();
        t_barrier_done_ignored();
        t_full_pool();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule